// File: doc/BRIEF.md
# Interrupt Controller Command Decoder

This block is the byte-wide register front end of a single eight-line interrupt controller. Software reaches it through one address bit, a write strobe and a read strobe. Writes to address 0 carry an initialization start word or an operation command. Writes to address 1 carry either the interrupt mask or the remaining initialization words, depending on where the initialization sequence stands. The block holds the control state: mask, priority rotation base, vector base, nesting and auto-EOI options, read selection, poll flag and special-mask flag.

The request and in-service registers live in the surrounding core, so they enter as inputs. The priority resolver also lives in the core, and its winning index enters as an input. The block reports its effect on those registers through one-cycle clear pulses and an initialization pulse. The core uses the initialization pulse to wipe its request and in-service state and to drop its interrupt output. For non-specific end-of-interrupt the block applies the same rotating priority rule that the resolver uses. Every strobe takes effect on the clock edge that samples it, and read data is registered.

Top module: `pic_cmd_decoder`

## Requirements
- R1: After reset the mask, rotation base, vector base, read data and all option flags are 0, and init_step_o is 0 (normal operation).
- R2: A write to address 0 with data bit 4 set clears mask, rotation base, vector base, read-select, poll, special mask, nesting, auto-EOI and rotate-on-auto-EOI. It pulses init_clr_o high for exactly one cycle, sets init_step_o to 1, and records data bit 0 as "fourth word expected".
- R3: At init_step_o 1, an address-1 write loads the vector base with the data ANDed with 0xF8 and moves to step 2.
- R4: At step 2, an address-1 write moves to step 3 if a fourth word was expected, and to step 0 otherwise. Its data changes no state.
- R5: At step 3, an address-1 write sets the nesting flag from data bit 4 and the auto-EOI flag from data bit 1, then returns to step 0.
- R6: At step 0, an address-1 write loads the mask register.
- R7: An address-0 write with bit 4 clear and bit 3 set is a mode command. Bit 2 arms a poll. Bit 1 set loads read-select from bit 0. Bit 6 set loads special mask from bit 5. A flag whose enable bit is clear keeps its value.
- R8: For other address-0 writes, bits 7:5 form a command. Commands 0 and 4 load rotate-on-auto-EOI from bit 7. Command 2 changes nothing and emits no pulse.
- R9: Commands 1 and 5 clear one in-service bit: the first set bit found scanning upward from the rotation base, modulo 8. The clear is a one-hot pulse on isr_clr_o in the cycle after the write. If no in-service bit is set, no pulse is emitted.
- R10: Command 5 also sets the rotation base to (cleared index + 1) mod 8. With nothing in service, the base is unchanged.
- R11: Command 3 clears in-service bit data[2:0]. Command 7 does the same and sets the base to (data[2:0] + 1) mod 8. Command 6 only sets the base to (data[2:0] + 1) mod 8.
- R12: Without a pending poll, a read of address 0 returns the in-service input when read-select is 1 and the request input otherwise. A read of address 1 returns the mask. The value appears on rdata_o in the cycle after the read strobe.
- R13: A read with a poll pending returns the resolver's winning index and pulses that bit on both irr_clr_o and isr_clr_o. If no request wins, the read returns 7 and emits no pulse. Either way the poll flag is cleared, so the next read is a normal read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_i | input | 1 | Register address bit |
| wdata_i | input | 8 | Write data |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| irr_i | input | 8 | Request register from the core |
| isr_i | input | 8 | In-service register from the core |
| win_vld_i | input | 1 | Resolver has a winning request |
| win_idx_i | input | 3 | Resolver's winning index |
| rdata_o | output | 8 | Registered read data |
| mask_o | output | 8 | Interrupt mask |
| prio_base_o | output | 3 | Rotation base (lowest-numbered priority slot) |
| vec_base_o | output | 8 | Vector base |
| init_step_o | output | 2 | Initialization step, 0 = normal operation |
| nested_o | output | 1 | Special fully nested mode |
| auto_eoi_o | output | 1 | Automatic end-of-interrupt |
| rot_aeoi_o | output | 1 | Rotate on automatic end-of-interrupt |
| spec_mask_o | output | 1 | Special mask mode |
| init_clr_o | output | 1 | One-cycle pulse: clear core state and drop the interrupt output |
| isr_clr_o | output | 8 | One-cycle in-service clear pulses |
| irr_clr_o | output | 8 | One-cycle request clear pulses (poll read) |

## Verification
The checks assume that the read and write strobes are never high in the same cycle, and one property watches that assumption at the inputs. They also assume that the resolver's index is meaningful only while its valid input is high. The stimulus drives every access as a single one-cycle strobe from a task, with at least one idle edge between accesses. The bench changes the request, in-service and resolver inputs only between accesses, so each read and each end-of-interrupt sees stable core state.

// File: rtl/pic_cmd_pkg.sv
package pic_cmd_pkg;

   typedef enum logic [1:0] {
      STEP_RUN  = 2'd0,
      STEP_VEC  = 2'd1,
      STEP_CASC = 2'd2,
      STEP_OPT  = 2'd3
   } init_step_t;

   typedef enum logic [2:0] {
      OC_ROT_CLR = 3'd0,
      OC_EOI     = 3'd1,
      OC_NOP     = 3'd2,
      OC_SEOI    = 3'd3,
      OC_ROT_SET = 3'd4,
      OC_REOI    = 3'd5,
      OC_SETPRI  = 3'd6,
      OC_RSEOI   = 3'd7
   } ocmd_t;

   // bit positions in command / initialization words
   localparam int B_NEED4   = 0;
   localparam int B_RSEL    = 0;
   localparam int B_RSEL_EN = 1;
   localparam int B_AEOI    = 1;
   localparam int B_POLL    = 2;
   localparam int B_MODE    = 3;
   localparam int B_INIT    = 4;
   localparam int B_NEST    = 4;
   localparam int B_SMM     = 5;
   localparam int B_SMM_EN  = 6;
   localparam int B_ROT     = 7;

endpackage

// File: rtl/pic_prio_find.sv
module pic_prio_find #(
   parameter  int LINES = 8,
   localparam int IDXW  = $clog2(LINES)
) (
   input  logic [LINES-1:0] req_i,
   input  logic [IDXW-1:0]  base_i,
   output logic             hit_o,
   output logic [IDXW-1:0]  idx_o
);

   logic [LINES-1:0] rot;
   logic [IDXW-1:0]  off;

   for (genvar i = 0; i < LINES; i++) begin : g_rot
      logic [IDXW-1:0] src;
      assign src    = IDXW'(i) + base_i;
      assign rot[i] = req_i[src];
   end

   always_comb begin
      off = '0;
      for (int j = LINES - 1; j >= 0; j--) begin
         if (rot[j]) off = IDXW'(j);
      end
   end

   assign hit_o = |rot;
   assign idx_o = off + base_i;

endmodule

// File: rtl/pic_wr_decode.sv
module pic_wr_decode
   import pic_cmd_pkg::*;
#(
   parameter  int DW    = 8,
   parameter  int LINES = 8,
   localparam int IDXW  = $clog2(LINES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_i,
   input  logic             addr_i,
   input  logic [DW-1:0]    wdata_i,
   input  logic [LINES-1:0] isr_i,
   input  logic             poll_take_i,
   output logic [LINES-1:0] mask_o,
   output logic [IDXW-1:0]  base_o,
   output logic [DW-1:0]    vec_o,
   output logic [1:0]       step_o,
   output logic             nest_o,
   output logic             aeoi_o,
   output logic             rot_o,
   output logic             smm_o,
   output logic             rsel_o,
   output logic             poll_o,
   output logic             init_clr_o,
   output logic [LINES-1:0] isr_clr_o
);

   localparam logic [DW-1:0] VEC_KEEP = ~DW'(LINES - 1);

   init_step_t       step_q;
   logic             need4_q;
   logic             eoi_hit;
   logic [IDXW-1:0]  eoi_idx;
   logic [IDXW-1:0]  didx;
   ocmd_t            cmd;

   assign didx = wdata_i[IDXW-1:0];
   assign cmd  = ocmd_t'(wdata_i[7:5]);

   pic_prio_find #(.LINES(LINES)) u_eoi_find (
      .req_i  (isr_i),
      .base_i (base_o),
      .hit_o  (eoi_hit),
      .idx_o  (eoi_idx)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mask_o     <= '0;
         base_o     <= '0;
         vec_o      <= '0;
         step_q     <= STEP_RUN;
         need4_q    <= 1'b0;
         nest_o     <= 1'b0;
         aeoi_o     <= 1'b0;
         rot_o      <= 1'b0;
         smm_o      <= 1'b0;
         rsel_o     <= 1'b0;
         poll_o     <= 1'b0;
         init_clr_o <= 1'b0;
         isr_clr_o  <= '0;
      end else begin
         init_clr_o <= 1'b0;
         isr_clr_o  <= '0;
         if (poll_take_i) poll_o <= 1'b0;
         if (wr_i && !addr_i) begin
            if (wdata_i[B_INIT]) begin
               mask_o     <= '0;
               base_o     <= '0;
               vec_o      <= '0;
               nest_o     <= 1'b0;
               aeoi_o     <= 1'b0;
               rot_o      <= 1'b0;
               smm_o      <= 1'b0;
               rsel_o     <= 1'b0;
               poll_o     <= 1'b0;
               need4_q    <= wdata_i[B_NEED4];
               step_q     <= STEP_VEC;
               init_clr_o <= 1'b1;
            end else if (wdata_i[B_MODE]) begin
               if (wdata_i[B_POLL])    poll_o <= 1'b1;
               if (wdata_i[B_RSEL_EN]) rsel_o <= wdata_i[B_RSEL];
               if (wdata_i[B_SMM_EN])  smm_o  <= wdata_i[B_SMM];
            end else begin
               case (cmd)
                  OC_ROT_CLR, OC_ROT_SET: rot_o <= wdata_i[B_ROT];
                  OC_EOI, OC_REOI: begin
                     if (eoi_hit) begin
                        isr_clr_o <= LINES'(1) << eoi_idx;
                        if (cmd == OC_REOI) base_o <= eoi_idx + 1'b1;
                     end
                  end
                  OC_SEOI:   isr_clr_o <= LINES'(1) << didx;
                  OC_SETPRI: base_o    <= didx + 1'b1;
                  OC_RSEOI: begin
                     isr_clr_o <= LINES'(1) << didx;
                     base_o    <= didx + 1'b1;
                  end
                  default: ;
               endcase
            end
         end else if (wr_i && addr_i) begin
            case (step_q)
               STEP_RUN: mask_o <= wdata_i[LINES-1:0];
               STEP_VEC: begin
                  vec_o  <= wdata_i & VEC_KEEP;
                  step_q <= STEP_CASC;
               end
               STEP_CASC: step_q <= need4_q ? STEP_OPT : STEP_RUN;
               STEP_OPT: begin
                  nest_o <= wdata_i[B_NEST];
                  aeoi_o <= wdata_i[B_AEOI];
                  step_q <= STEP_RUN;
               end
               default: step_q <= STEP_RUN;
            endcase
         end
      end
   end

   assign step_o = step_q;

endmodule

// File: rtl/pic_rd_path.sv
module pic_rd_path #(
   parameter  int DW    = 8,
   parameter  int LINES = 8,
   localparam int IDXW  = $clog2(LINES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rd_i,
   input  logic             addr_i,
   input  logic             poll_i,
   input  logic             rsel_i,
   input  logic [LINES-1:0] irr_i,
   input  logic [LINES-1:0] isr_i,
   input  logic [LINES-1:0] mask_i,
   input  logic             win_vld_i,
   input  logic [IDXW-1:0]  win_idx_i,
   output logic [DW-1:0]    rdata_o,
   output logic [LINES-1:0] irr_clr_o,
   output logic [LINES-1:0] isr_clr_o,
   output logic             poll_take_o
);

   localparam logic [DW-1:0] NO_WIN = DW'(LINES - 1);

   logic [LINES-1:0] reg_sel;

   assign poll_take_o = rd_i && poll_i;
   assign reg_sel     = addr_i ? mask_i : (rsel_i ? isr_i : irr_i);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdata_o   <= '0;
         irr_clr_o <= '0;
         isr_clr_o <= '0;
      end else begin
         irr_clr_o <= '0;
         isr_clr_o <= '0;
         if (rd_i) begin
            if (poll_i) begin
               if (win_vld_i) begin
                  rdata_o   <= DW'(win_idx_i);
                  irr_clr_o <= LINES'(1) << win_idx_i;
                  isr_clr_o <= LINES'(1) << win_idx_i;
               end else begin
                  rdata_o <= NO_WIN;
               end
            end else begin
               rdata_o <= DW'(reg_sel);
            end
         end
      end
   end

endmodule

// File: rtl/pic_cmd_decoder.sv
module pic_cmd_decoder #(
   parameter  int DW    = 8,
   parameter  int LINES = 8,
   localparam int IDXW  = $clog2(LINES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             addr_i,
   input  logic [DW-1:0]    wdata_i,
   input  logic             wr_i,
   input  logic             rd_i,
   input  logic [LINES-1:0] irr_i,
   input  logic [LINES-1:0] isr_i,
   input  logic             win_vld_i,
   input  logic [IDXW-1:0]  win_idx_i,
   output logic [DW-1:0]    rdata_o,
   output logic [LINES-1:0] mask_o,
   output logic [IDXW-1:0]  prio_base_o,
   output logic [DW-1:0]    vec_base_o,
   output logic [1:0]       init_step_o,
   output logic             nested_o,
   output logic             auto_eoi_o,
   output logic             rot_aeoi_o,
   output logic             spec_mask_o,
   output logic             init_clr_o,
   output logic [LINES-1:0] isr_clr_o,
   output logic [LINES-1:0] irr_clr_o
);

   if (DW != 8) begin : g_bad_dw
      $error("pic_cmd_decoder: command words are byte wide, DW must be 8");
   end
   if ((1 << IDXW) != LINES || LINES < 2 || LINES > 8) begin : g_bad_lines
      $error("pic_cmd_decoder: LINES must be a power of two from 2 to 8");
   end

   logic             poll_w;
   logic             rsel_w;
   logic             poll_take_w;
   logic [LINES-1:0] wr_isr_clr;
   logic [LINES-1:0] rd_isr_clr;

   pic_wr_decode #(.DW(DW), .LINES(LINES)) u_wr (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_i        (wr_i),
      .addr_i      (addr_i),
      .wdata_i     (wdata_i),
      .isr_i       (isr_i),
      .poll_take_i (poll_take_w),
      .mask_o      (mask_o),
      .base_o      (prio_base_o),
      .vec_o       (vec_base_o),
      .step_o      (init_step_o),
      .nest_o      (nested_o),
      .aeoi_o      (auto_eoi_o),
      .rot_o       (rot_aeoi_o),
      .smm_o       (spec_mask_o),
      .rsel_o      (rsel_w),
      .poll_o      (poll_w),
      .init_clr_o  (init_clr_o),
      .isr_clr_o   (wr_isr_clr)
   );

   pic_rd_path #(.DW(DW), .LINES(LINES)) u_rd (
      .clk         (clk),
      .rst_n       (rst_n),
      .rd_i        (rd_i),
      .addr_i      (addr_i),
      .poll_i      (poll_w),
      .rsel_i      (rsel_w),
      .irr_i       (irr_i),
      .isr_i       (isr_i),
      .mask_i      (mask_o),
      .win_vld_i   (win_vld_i),
      .win_idx_i   (win_idx_i),
      .rdata_o     (rdata_o),
      .irr_clr_o   (irr_clr_o),
      .isr_clr_o   (rd_isr_clr),
      .poll_take_o (poll_take_w)
   );

   assign isr_clr_o = wr_isr_clr | rd_isr_clr;

endmodule

// File: rtl/pic_cmd_chk.sv
module pic_cmd_chk #(
   parameter  int DW    = 8,
   parameter  int LINES = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             addr_i,
   input logic [DW-1:0]    wdata_i,
   input logic             wr_i,
   input logic             rd_i,
   input logic             win_vld_i,
   input logic [DW-1:0]    rdata_o,
   input logic [LINES-1:0] mask_o,
   input logic [$clog2(LINES)-1:0] prio_base_o,
   input logic [1:0]       init_step_o,
   input logic             init_clr_o,
   input logic [LINES-1:0] isr_clr_o,
   input logic [LINES-1:0] irr_clr_o,
   input logic             poll_w
);

   a_r12_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_i && rd_i));

   a_r2_init_entry: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && !addr_i && wdata_i[4]) |=>
         (init_clr_o && mask_o == '0 && prio_base_o == '0 && init_step_o == 2'd1));

   a_r3_vec_step: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && addr_i && init_step_o == 2'd1) |=> (init_step_o == 2'd2));

   a_r6_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && addr_i && init_step_o == 2'd0) |=> (mask_o == $past(wdata_i[LINES-1:0])));

   a_r9_onehot_clear: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(isr_clr_o));

   a_r12_mask_read: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_i && !poll_w && addr_i) |=> (rdata_o == DW'($past(mask_o))));

   a_r13_poll_empty: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_i && poll_w && !win_vld_i) |=> (rdata_o == DW'(LINES - 1) && irr_clr_o == '0));

   a_r13_poll_once: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_i && poll_w) |=> !poll_w);

   a_r13_irr_clr_cause: assert property (@(posedge clk) disable iff (!rst_n)
      (irr_clr_o != '0) |-> $past(rd_i && poll_w));

endmodule

bind pic_cmd_decoder pic_cmd_chk #(.DW(DW), .LINES(LINES)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .addr_i      (addr_i),
   .wdata_i     (wdata_i),
   .wr_i        (wr_i),
   .rd_i        (rd_i),
   .win_vld_i   (win_vld_i),
   .rdata_o     (rdata_o),
   .mask_o      (mask_o),
   .prio_base_o (prio_base_o),
   .init_step_o (init_step_o),
   .init_clr_o  (init_clr_o),
   .isr_clr_o   (isr_clr_o),
   .irr_clr_o   (irr_clr_o),
   .poll_w      (poll_w)
);

// File: tb/test_pic_cmd_decoder.sv
`timescale 1ns/1ps
module test_pic_cmd_decoder;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       addr_i = 1'b0;
   logic [7:0] wdata_i = '0;
   logic       wr_i = 1'b0;
   logic       rd_i = 1'b0;
   logic [7:0] irr_i = '0;
   logic [7:0] isr_i = '0;
   logic       win_vld_i = 1'b0;
   logic [2:0] win_idx_i = '0;
   logic [7:0] rdata_o, mask_o, vec_base_o, isr_clr_o, irr_clr_o;
   logic [2:0] prio_base_o;
   logic [1:0] init_step_o;
   logic       nested_o, auto_eoi_o, rot_aeoi_o, spec_mask_o, init_clr_o;

   int checks = 0;
   int failures = 0;
   bit done = 0;
   logic [7:0] exp_q[$];
   string      tag_q[$];

   always #2 clk = ~clk;

   pic_cmd_decoder i_pic_cmd_decoder (
      .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .wdata_i(wdata_i),
      .wr_i(wr_i), .rd_i(rd_i), .irr_i(irr_i), .isr_i(isr_i),
      .win_vld_i(win_vld_i), .win_idx_i(win_idx_i), .rdata_o(rdata_o),
      .mask_o(mask_o), .prio_base_o(prio_base_o), .vec_base_o(vec_base_o),
      .init_step_o(init_step_o), .nested_o(nested_o), .auto_eoi_o(auto_eoi_o),
      .rot_aeoi_o(rot_aeoi_o), .spec_mask_o(spec_mask_o), .init_clr_o(init_clr_o),
      .isr_clr_o(isr_clr_o), .irr_clr_o(irr_clr_o)
   );

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr_op(input logic a, input logic [7:0] d);
      @(negedge clk);
      addr_i = a; wdata_i = d; wr_i = 1'b1;
      @(negedge clk);
      wr_i = 1'b0;
   endtask

   // driver: pushes the expected read value, monitor compares it
   task automatic rd_op(input logic a, input logic [7:0] exp, input string tag);
      @(negedge clk);
      addr_i = a; rd_i = 1'b1;
      exp_q.push_back(exp);
      tag_q.push_back(tag);
      @(negedge clk);
      rd_i = 1'b0;
   endtask

   initial begin : monitor
      forever begin
         @(posedge clk);
         if (rd_i && rst_n) begin
            @(negedge clk);
            if (exp_q.size() == 0) begin
               checks++; failures++;
               $display("FAIL read: actual=%0h expected=none", rdata_o);
            end else begin
               chk(tag_q.pop_front(), {8'h0, rdata_o}, {8'h0, exp_q.pop_front()});
            end
         end
      end
   end

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin : stim
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 mask", 16'(mask_o), 16'h0);
      chk("R1 base", 16'(prio_base_o), 16'h0);
      chk("R1 step", 16'(init_step_o), 16'h0);
      chk("R1 rdata", 16'(rdata_o), 16'h0);
      chk("R1 flags", 16'({nested_o, auto_eoi_o, rot_aeoi_o, spec_mask_o, init_clr_o}), 16'h0);

      wr_op(1'b1, 8'hA5);
      chk("R6 mask", 16'(mask_o), 16'hA5);
      wr_op(1'b0, 8'hC2);                      // set base 3 before init
      chk("R11 setpri", 16'(prio_base_o), 16'h3);

      // R2 init with fourth word
      wr_op(1'b0, 8'h11);
      chk("R2 pulse", 16'(init_clr_o), 16'h1);
      chk("R2 step", 16'(init_step_o), 16'h1);
      chk("R2 mask", 16'(mask_o), 16'h0);
      chk("R2 base", 16'(prio_base_o), 16'h0);
      @(negedge clk);
      chk("R2 pulse one cycle", 16'(init_clr_o), 16'h0);
      wr_op(1'b1, 8'h47);
      chk("R3 vec", 16'(vec_base_o), 16'h40);
      chk("R3 step", 16'(init_step_o), 16'h2);
      wr_op(1'b1, 8'hFF);
      chk("R4 to step3", 16'(init_step_o), 16'h3);
      chk("R4 data ignored", 16'(mask_o), 16'h0);
      wr_op(1'b1, 8'h12);
      chk("R5 nest/aeoi", 16'({nested_o, auto_eoi_o}), 16'h3);
      chk("R5 step", 16'(init_step_o), 16'h0);

      // R2 init without fourth word clears options
      wr_op(1'b0, 8'h10);
      chk("R2 clears nest/aeoi", 16'({nested_o, auto_eoi_o}), 16'h0);
      wr_op(1'b1, 8'h08);
      chk("R3 vec", 16'(vec_base_o), 16'h08);
      wr_op(1'b1, 8'h00);
      chk("R4 to run", 16'(init_step_o), 16'h0);
      wr_op(1'b1, 8'h3C);
      chk("R6 mask after init", 16'(mask_o), 16'h3C);

      // R12 reads, R7 read-select
      irr_i = 8'h81; isr_i = 8'h24;
      rd_op(1'b0, 8'h81, "R12 irr read");
      rd_op(1'b1, 8'h3C, "R12 mask read");
      wr_op(1'b0, 8'h0B);
      rd_op(1'b0, 8'h24, "R7 select isr");
      wr_op(1'b0, 8'h09);                      // enable bit clear: keep isr
      rd_op(1'b0, 8'h24, "R7 select kept");
      wr_op(1'b0, 8'h0A);
      rd_op(1'b0, 8'h81, "R7 select irr");

      // R7 special mask
      wr_op(1'b0, 8'h68);
      chk("R7 smm set", 16'(spec_mask_o), 16'h1);
      wr_op(1'b0, 8'h08);
      chk("R7 smm kept", 16'(spec_mask_o), 16'h1);
      wr_op(1'b0, 8'h48);
      chk("R7 smm clear", 16'(spec_mask_o), 16'h0);

      // R8 rotate flag and no-op
      wr_op(1'b0, 8'h80);
      chk("R8 rot set", 16'(rot_aeoi_o), 16'h1);
      wr_op(1'b0, 8'h00);
      chk("R8 rot clear", 16'(rot_aeoi_o), 16'h0);
      wr_op(1'b0, 8'h80);
      wr_op(1'b0, 8'h47);
      chk("R8 nop rot", 16'(rot_aeoi_o), 16'h1);
      chk("R8 nop pulse", 16'(isr_clr_o), 16'h0);
      chk("R8 nop base", 16'(prio_base_o), 16'h0);

      // R9 non-specific EOI
      wr_op(1'b0, 8'h20);
      chk("R9 eoi base0", 16'(isr_clr_o), 16'h04);
      @(negedge clk);
      chk("R9 pulse one cycle", 16'(isr_clr_o), 16'h00);
      wr_op(1'b0, 8'hC5);
      chk("R11 setpri", 16'(prio_base_o), 16'h6);
      isr_i = 8'h22;
      wr_op(1'b0, 8'h20);
      chk("R9 eoi rotated", 16'(isr_clr_o), 16'h02);
      chk("R9 base kept", 16'(prio_base_o), 16'h6);
      wr_op(1'b0, 8'hA0);
      chk("R10 reoi clear", 16'(isr_clr_o), 16'h02);
      chk("R10 reoi base", 16'(prio_base_o), 16'h2);
      isr_i = 8'h00;
      wr_op(1'b0, 8'hA0);
      chk("R9 empty no pulse", 16'(isr_clr_o), 16'h00);
      chk("R10 empty base", 16'(prio_base_o), 16'h2);

      // R11 specific forms
      wr_op(1'b0, 8'h66);
      chk("R11 seoi", 16'(isr_clr_o), 16'h40);
      chk("R11 seoi base", 16'(prio_base_o), 16'h2);
      wr_op(1'b0, 8'hE3);
      chk("R11 rseoi", 16'(isr_clr_o), 16'h08);
      chk("R11 rseoi base", 16'(prio_base_o), 16'h4);
      wr_op(1'b0, 8'hE7);
      chk("R11 base wrap", 16'(prio_base_o), 16'h0);

      // R13 poll
      wr_op(1'b0, 8'h0C);
      win_vld_i = 1'b1; win_idx_i = 3'd5;
      rd_op(1'b1, 8'h05, "R13 poll index");
      chk("R13 irr clr", 16'(irr_clr_o), 16'h20);
      chk("R13 isr clr", 16'(isr_clr_o), 16'h20);
      rd_op(1'b0, 8'h81, "R13 poll cleared");
      chk("R13 no pulse", 16'(irr_clr_o), 16'h00);
      wr_op(1'b0, 8'h0C);
      win_vld_i = 1'b0;
      rd_op(1'b0, 8'h07, "R13 poll empty");
      chk("R13 empty irr clr", 16'(irr_clr_o), 16'h00);
      chk("R13 empty isr clr", 16'(isr_clr_o), 16'h00);
      rd_op(1'b1, 8'h3C, "R13 after empty poll");

      // R2 init clears read-select and poll
      isr_i = 8'h55;
      wr_op(1'b0, 8'h0B);
      wr_op(1'b0, 8'h0C);
      wr_op(1'b0, 8'h10);
      rd_op(1'b0, 8'h81, "R2 select and poll cleared");
      wr_op(1'b1, 8'h00);
      wr_op(1'b1, 8'h00);
      chk("R4 run again", 16'(init_step_o), 16'h0);

      repeat (3) @(negedge clk);
      if (exp_q.size() != 0) begin
         checks++; failures++;
         $display("FAIL R12 reads: actual=%0d expected=0 pending", exp_q.size());
      end
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule